// File: doc/BRIEF.md
# Dual-Capture Timer Channel

This block is one 16-bit timer channel used for input measurement. A free-running counter advances on a selected counter-clock enable. On chosen edges of input A it copies the count into one of two capture registers. Software gets pulse width, period or duty cycle by subtracting the two captures. Captures go to register A and register B in turn, under arming rules: B never loads first after a restart, and A never loads twice in a row. If a capture lands in a register whose last value was never read, a sticky overrun flag is set.

The counter is restarted and cleared by a trigger. A trigger comes from one of four sources: a software command, a broadcast sync line, a compare match against a programmable RC value, or a selected edge of input A or input B. A trigger is held pending and applied only on the next active counter-clock enable. Before its first trigger the counter stays stopped at zero.

Top module: `tcap_channel`

## Requirements
- R1: After reset, count, capA and capB are 0, every flag is 0, and the counter stays stopped at 0 until a trigger has been applied.
- R2: A trigger is applied only on a cycle where cntEn is high, and sets the count to 0 on that edge. Until then the count holds its value, even though the trigger came earlier.
- R3: Writing wrAddr=1 with wrData[0]=1 is a software trigger. A one-cycle syncIn pulse has the same effect.
- R4: When ctrl bit 7 (compare-trigger enable) is 1 and a running count equals RC (wrAddr=2), the next cntEn edge sets the count to 0 instead of RC+1. cpcFlag is set whenever the running count equals RC.
- R5: The external trigger takes input A when ctrl bit 6 is 0 and input B when it is 1. Its edge is chosen by ctrl[5:4]. An input must be stable for more than one clock cycle to be seen.
- R6: Edge selects use the code 0 = none, 1 = rising, 2 = falling, 3 = both. ctrl[1:0] chooses the input-A edge that loads capA, and ctrl[3:2] chooses the one that loads capB. The ctrl register is written at wrAddr=0.
- R7: capA loads the current count only if it has not loaded since the last trigger, or if capB has loaded since capA's last load. Otherwise the edge is ignored.
- R8: capB loads only if capA has loaded since the last trigger, or since capB's last load. Otherwise the edge is ignored.
- R9: A load into a register whose unreadA or unreadB marker is set sets the sticky lovrFlag, and the new value replaces the old one. A rdA or rdB pulse clears that register's marker.
- R10: A cntEn edge at count 0xFFFF wraps the count to 0 and sets the sticky ovfFlag. A rdStat pulse clears lovrFlag, ovfFlag and cpcFlag, unless a new event sets them in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntEn | input | 1 | Counter clock enable (active counter edge) |
| tioA | input | 1 | Measured input A (asynchronous) |
| tioB | input | 1 | Input B, external trigger only (asynchronous) |
| syncIn | input | 1 | Broadcast sync, same as software trigger |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 ctrl, 1 command, 2 RC |
| wrData | input | 16 | Write data |
| rdA | input | 1 | Read strobe for capA |
| rdB | input | 1 | Read strobe for capB |
| rdStat | input | 1 | Status read strobe |
| count | output | 16 | Counter value |
| capA | output | 16 | Capture register A |
| capB | output | 16 | Capture register B |
| lovrFlag | output | 1 | Sticky load overrun |
| ovfFlag | output | 1 | Sticky counter overflow |
| cpcFlag | output | 1 | Sticky RC compare |
| unreadA | output | 1 | capA holds an unread value |
| unreadB | output | 1 | capB holds an unread value |

## Verification
The assertions check the following on every cycle:
- the count never moves without cntEn;
- an applied trigger always leaves the count at zero;
- capture registers hold unless loaded, and A and B never load together;
- overrun and overflow stay sticky until a status read.

The bench scenarios show the ordering behaviour:
- captures alternate across several edge patterns;
- B is refused when no A came first, and a second A is refused;
- triggers wait for cntEn;
- compare restart, external input selection and the full 16-bit wrap.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeSel_e;

  typedef struct packed {
    logic     rcTrigEn;
    logic     extSelB;
    edgeSel_e extEdge;
    edgeSel_e ldBSel;
    edgeSel_e ldASel;
  } cfg_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic loadA;
    logic loadB;
  } dpStrobe_t;

  function automatic logic edgeHit(edgeSel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_RISE: edgeHit = rise;
      EDGE_FALL: edgeHit = fall;
      EDGE_BOTH: edgeHit = rise | fall;
      default:   edgeHit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tcap_edge.sv
module tcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], din};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign rise = syncQ[STAGES-1] & ~prevQ;
  assign fall = ~syncQ[STAGES-1] & prevQ;

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rise && fall)); // R6
endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] rcVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capA,
  output logic [CNT_W-1:0] capB,
  output logic             rcHit,
  output logic             atMax
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.clrCnt) begin
      count <= '0;
    end else if (strb.incCnt) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA <= '0;
      capB <= '0;
    end else begin
      if (strb.loadA) capA <= count;
      if (strb.loadB) capB <= count;
    end
  end

  assign rcHit = (count == rcVal);
  assign atMax = &count;

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(count)); // R2
  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (count == '0)); // R2
  AST_CAPA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadA |=> $stable(capA)); // R7
  AST_CAPB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadB |=> $stable(capB)); // R8
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             syncIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdA,
  input  logic             rdB,
  input  logic             rdStat,
  input  logic             riseA,
  input  logic             fallA,
  input  logic             riseB,
  input  logic             fallB,
  input  logic             rcHit,
  input  logic             atMax,
  output dpStrobe_t        strb,
  output logic [CNT_W-1:0] rcVal,
  output logic             lovrFlag,
  output logic             ovfFlag,
  output logic             cpcFlag,
  output logic             unreadA,
  output logic             unreadB
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t cfg;
  logic runQ, pendQ, aArmed, bArmed;
  logic swTrig, extHit, trigNow, trigAll, apply, wrap;
  logic evA, evB, loadA, loadB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg   <= '0;
      rcVal <= '1;
    end else if (wrEn) begin
      if (wrAddr == 2'd0) cfg   <= cfg_t'(wrData[CFG_W-1:0]);
      if (wrAddr == 2'd2) rcVal <= wrData;
    end
  end

  assign swTrig  = wrEn && (wrAddr == 2'd1) && wrData[0];
  assign extHit  = cfg.extSelB ? edgeHit(cfg.extEdge, riseB, fallB)
                               : edgeHit(cfg.extEdge, riseA, fallA);
  assign trigNow = swTrig | syncIn | extHit | (cfg.rcTrigEn & rcHit & runQ);
  assign trigAll = pendQ | trigNow;
  assign apply   = cntEn & trigAll;
  assign wrap    = strb.incCnt & atMax;

  assign evA   = edgeHit(cfg.ldASel, riseA, fallA);
  assign evB   = edgeHit(cfg.ldBSel, riseA, fallA);
  assign loadA = evA & aArmed;
  assign loadB = evB & bArmed & ~loadA;

  always_comb begin
    strb.clrCnt = apply;
    strb.incCnt = cntEn & runQ & ~apply;
    strb.loadA  = loadA;
    strb.loadB  = loadB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      runQ  <= runQ | apply;
      pendQ <= apply ? 1'b0 : trigAll;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aArmed <= 1'b1;
      bArmed <= 1'b0;
    end else if (apply) begin
      aArmed <= 1'b1;
      bArmed <= 1'b0;
    end else if (loadA) begin
      aArmed <= 1'b0;
      bArmed <= 1'b1;
    end else if (loadB) begin
      aArmed <= 1'b1;
      bArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unreadA <= 1'b0;
      unreadB <= 1'b0;
    end else begin
      if (loadA)    unreadA <= 1'b1;
      else if (rdA) unreadA <= 1'b0;
      if (loadB)    unreadB <= 1'b1;
      else if (rdB) unreadB <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lovrFlag <= 1'b0;
      ovfFlag  <= 1'b0;
      cpcFlag  <= 1'b0;
    end else begin
      if ((loadA & unreadA) | (loadB & unreadB)) lovrFlag <= 1'b1;
      else if (rdStat)                           lovrFlag <= 1'b0;
      if (wrap)        ovfFlag <= 1'b1;
      else if (rdStat) ovfFlag <= 1'b0;
      if (runQ & rcHit) cpcFlag <= 1'b1;
      else if (rdStat)  cpcFlag <= 1'b0;
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadA && strb.loadB)); // R8
  AST_ARM_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadA && !apply) |=> (bArmed && !aArmed)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lovrFlag && !rdStat) |=> lovrFlag); // R9
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> ovfFlag); // R10
  AST_STOPPED_NO_INC: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !strb.incCnt); // R1
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             tioA,
  input  logic             tioB,
  input  logic             syncIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdA,
  input  logic             rdB,
  input  logic             rdStat,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capA,
  output logic [CNT_W-1:0] capB,
  output logic             lovrFlag,
  output logic             ovfFlag,
  output logic             cpcFlag,
  output logic             unreadA,
  output logic             unreadB
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] tioVec, riseVec, fallVec;
  dpStrobe_t       strb;
  logic [CNT_W-1:0] rcVal;
  logic            rcHit, atMax;

  assign tioVec = {tioB, tioA};

  for (genvar g = 0; g < N_IN; g++) begin : g_edge
    tcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk (clk),
      .rstN(rstN),
      .din (tioVec[g]),
      .rise(riseVec[g]),
      .fall(fallVec[g])
    );
  end

  tcap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cntEn   (cntEn),
    .syncIn  (syncIn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdA     (rdA),
    .rdB     (rdB),
    .rdStat  (rdStat),
    .riseA   (riseVec[0]),
    .fallA   (fallVec[0]),
    .riseB   (riseVec[1]),
    .fallB   (fallVec[1]),
    .rcHit   (rcHit),
    .atMax   (atMax),
    .strb    (strb),
    .rcVal   (rcVal),
    .lovrFlag(lovrFlag),
    .ovfFlag (ovfFlag),
    .cpcFlag (cpcFlag),
    .unreadA (unreadA),
    .unreadB (unreadB)
  );

  tcap_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .cntEn(cntEn),
    .strb (strb),
    .rcVal(rcVal),
    .count(count),
    .capA (capA),
    .capB (capB),
    .rcHit(rcHit),
    .atMax(atMax)
  );
endmodule

// File: tb/tcap_channel_bench.sv
module tcap_channel_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEn = 0, tioA = 0, tioB = 0, syncIn = 0, wrEn = 0;
  logic [1:0]  wrAddr = 0;
  logic [15:0] wrData = 0;
  logic rdA = 0, rdB = 0, rdStat = 0;
  logic [15:0] count, capA, capB;
  logic lovrFlag, ovfFlag, cpcFlag, unreadA, unreadB;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tcap_channel u_tcap_channel (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .tioA(tioA), .tioB(tioB),
    .syncIn(syncIn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdA(rdA), .rdB(rdB), .rdStat(rdStat), .count(count), .capA(capA),
    .capB(capB), .lovrFlag(lovrFlag), .ovfFlag(ovfFlag), .cpcFlag(cpcFlag),
    .unreadA(unreadA), .unreadB(unreadB)
  );

  localparam int NV = 4;
  localparam int       VSTEP [NV] = '{5, 3, 4, 2};
  localparam bit       VLVL  [NV] = '{1, 0, 1, 0};
  localparam bit [15:0] VEXPA[NV] = '{16'd5, 16'd5, 16'd12, 16'd12};
  localparam bit [15:0] VEXPB[NV] = '{16'd0, 16'd8, 16'd8, 16'd14};

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(int n);
    cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic swTrigRestart();
    wr(2'd1, 16'd1);
    step(1);
  endtask

  task automatic pulseRd(bit a, bit b, bit s);
    rdA = a; rdB = b; rdStat = s;
    @(negedge clk);
    rdA = 0; rdB = 0; rdStat = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 count", count, 16'd0);
    chk("R1 capA", capA, 16'd0);
    chk("R1 capB", capB, 16'd0);
    chk("R1 flags", {11'd0, lovrFlag, ovfFlag, cpcFlag, unreadA, unreadB}, 16'd0);
    wr(2'd0, 16'h0009);  // R6 ldA rise, ldB fall
    step(3);
    chk("R1 stopped before trigger", count, 16'd0);
    swTrigRestart();     // R3
    chk("R3 sw trigger count", count, 16'd0);

    for (int i = 0; i < NV; i++) begin
      step(VSTEP[i]);
      tioA = VLVL[i];
      cyc(4);
      chk("R7 vector capA", capA, VEXPA[i]);
      chk("R8 vector capB", capB, VEXPB[i]);
      pulseRd(1, 1, 0);
    end
    chk("R9 no overrun when read", {15'd0, lovrFlag}, 16'd0);

    // R2 trigger waits for cntEn
    wr(2'd1, 16'd1);
    cyc(3);
    chk("R2 held before cntEn", count, 16'd14);
    step(1);
    chk("R2 zero at cntEn", count, 16'd0);
    step(2);
    chk("R2 runs after", count, 16'd2);

    // R3 sync input
    syncIn = 1'b1; cyc(1); syncIn = 1'b0;
    cyc(2);
    chk("R3 sync held", count, 16'd2);
    step(1);
    chk("R3 sync zero", count, 16'd0);

    // R5 external trigger from B, rising
    wr(2'd0, 16'h0059);
    step(3);
    tioB = 1'b1;
    cyc(5);
    chk("R5 ext held", count, 16'd3);
    step(1);
    chk("R5 ext B restart", count, 16'd0);
    tioB = 1'b0;
    cyc(4);

    // R8 B refused without A
    wr(2'd0, 16'h000C);
    swTrigRestart();
    step(4);
    tioA = 1'b1; cyc(4);
    tioA = 1'b0; cyc(4);
    chk("R8 B ignored without A", capB, 16'd14);
    chk("R8 no unreadB", {15'd0, unreadB}, 16'd0);

    // R7 second A refused
    wr(2'd0, 16'h0003);
    swTrigRestart();
    step(3);
    tioA = 1'b1; cyc(4);
    chk("R7 first A loads", capA, 16'd3);
    step(2);
    tioA = 1'b0; cyc(4);
    chk("R7 second A ignored", capA, 16'd3);
    chk("R9 unreadA set", {15'd0, unreadA}, 16'd1);

    // R9 overrun and overwrite
    wr(2'd0, 16'h0009);
    swTrigRestart();
    step(2);
    tioA = 1'b1; cyc(4);
    chk("R9 overwrite capA", capA, 16'd2);
    chk("R9 overrun set", {15'd0, lovrFlag}, 16'd1);
    pulseRd(1, 0, 1);
    chk("R10 stat read clears overrun", {15'd0, lovrFlag}, 16'd0);
    chk("R9 unreadA cleared", {15'd0, unreadA}, 16'd0);
    step(1);
    tioA = 1'b0; cyc(4);
    chk("R8 B after A", capB, 16'd3);
    chk("R9 no overrun on read B", {15'd0, lovrFlag}, 16'd0);
    pulseRd(0, 1, 0);

    // R4 RC compare trigger
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0089);
    pulseRd(0, 0, 1);
    swTrigRestart();
    step(3);
    chk("R4 at RC", count, 16'd3);
    chk("R4 cpcFlag", {15'd0, cpcFlag}, 16'd1);
    step(1);
    chk("R4 restart at RC", count, 16'd0);
    step(5);
    chk("R4 periodic", count, 16'd1);

    // R10 overflow
    wr(2'd0, 16'h0009);
    pulseRd(0, 0, 1);
    swTrigRestart();
    step(65535);
    chk("R10 at max", count, 16'hFFFF);
    chk("R10 no ovf yet", {15'd0, ovfFlag}, 16'd0);
    step(1);
    chk("R10 wrap", count, 16'd0);
    chk("R10 ovf set", {15'd0, ovfFlag}, 16'd1);
    pulseRd(0, 0, 1);
    chk("R10 ovf cleared", {15'd0, ovfFlag}, 16'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule